// File: doc/BRIEF.md
# Supervisor Trap-Return Control Unit

This block carries out a return from a supervisor-level trap handler in a core that has five privilege modes: machine (M), supervisor (S), user (U), and the two guest modes that run under a hypervisor, guest-supervisor (GS) and guest-user (GU). The CSR file, the instruction decoder and the trap-vector logic sit outside it and meet it only at its ports. The decoder pulses a one-cycle request and presents the current mode, two trap-return lock bits and the relevant status fields. It also presents two saved exception PCs: the supervisor one and the guest one.

One cycle after each request the block reports exactly one outcome. The first is a fault strobe with a cause code, when the current mode may not return. The second is a done strobe with three things: the next privilege mode, the redirect PC, and the new status field values. Each group of status fields comes with its own write enable. There are two return paths. The native path updates the supervisor status fields and the saved-virtualization bit. The guest path, taken from guest-supervisor mode, updates only the guest status copy.

Hypervisor support is a build parameter. Without it, the guest modes do not exist and the saved-virtualization bit plays no part.

Top module: `trapret_unit`

## Requirements
- R1: While `rst` is high and on the first sample after it falls, `done_o` and `fault_o` are 0.
- R2: Each cycle with `req_i`=1 produces, one clock later, exactly one of `done_o` or `fault_o`. A cycle with `req_i`=0 produces neither. Back-to-back requests each get their own result.
- R3: Mode M (code 3) always completes. Mode U (code 0) always faults with cause 2 (illegal instruction). Mode GU (code 4) faults with cause 22 (virtual instruction) when hypervisor support is on.
- R4: Mode S (code 1) faults with cause 2 when `lock_m_i`=1, and completes otherwise.
- R5: Mode GS (code 5) faults with cause 22 when `lock_h_i`=1, and completes otherwise. `lock_m_i` has no effect on this mode.
- R6: A native return (from M or S) picks the next mode from {`pp_i`,`pv_i`}: 00 gives U (0), 01 gives GU (4), 10 gives S (1), 11 gives GS (5).
- R7: A native return asserts `st_wr_o` and sets `ie_o`=old `pie_i`, `pie_o`=1 and `pp_o`=0. It asserts `pv_wr_o` with `pv_o`=0 when hypervisor support is on. It loads `pc_o` from `epc_i` and leaves `g_wr_o`=0.
- R8: A guest return (from GS) asserts `g_wr_o` and sets `g_ie_o`=old `g_pie_i`, `g_pie_o`=1 and `g_pp_o`=0. It sets `next_mode_o` to GU when `g_pp_i`=0 and to GS when `g_pp_i`=1. It loads `pc_o` from `g_epc_i` and leaves `st_wr_o` and `pv_wr_o` at 0.
- R9: A faulting request asserts no write enable and gives no done strobe. `cause_o` is 2 or 22, and `pc_o` and all field outputs read 0.
- R10: Mode codes 2, 6 and 7 fault with cause 2.
- R11: With `HYP_EN`=0, codes 4 and 5 fault with cause 2. A native return then goes to S when `pp_i`=1 and to U when `pp_i`=0, whatever `pv_i` is, and `pv_wr_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle trap-return request |
| mode_i | input | 3 | Current privilege mode code |
| lock_m_i | input | 1 | Machine-level lock: a return from S mode faults |
| lock_h_i | input | 1 | Hypervisor-level lock: a return from GS mode faults |
| pp_i | input | 1 | Supervisor saved previous privilege |
| pie_i | input | 1 | Supervisor saved previous interrupt enable |
| pv_i | input | 1 | Saved previous virtualization bit |
| g_pp_i | input | 1 | Guest saved previous privilege |
| g_pie_i | input | 1 | Guest saved previous interrupt enable |
| epc_i | input | XLEN | Supervisor exception PC |
| g_epc_i | input | XLEN | Guest exception PC |
| done_o | output | 1 | Return completed |
| fault_o | output | 1 | Return faulted |
| cause_o | output | 5 | Fault cause (2 or 22), 0 otherwise |
| next_mode_o | output | 3 | Mode after the return |
| pc_o | output | XLEN | Redirect PC |
| st_wr_o | output | 1 | Write enable, supervisor status fields |
| ie_o | output | 1 | New supervisor interrupt enable |
| pie_o | output | 1 | New supervisor saved interrupt enable |
| pp_o | output | 1 | New supervisor saved privilege |
| pv_wr_o | output | 1 | Write enable, saved virtualization bit |
| pv_o | output | 1 | New saved virtualization bit |
| g_wr_o | output | 1 | Write enable, guest status fields |
| g_ie_o | output | 1 | New guest interrupt enable |
| g_pie_o | output | 1 | New guest saved interrupt enable |
| g_pp_o | output | 1 | New guest saved privilege |

## Verification
A single request resolves both a permission decision and a return computation in the same cycle. Only one of them may reach the ports, so a locked or forbidden mode must suppress every write enable and the redirect. The bench provokes this collision by presenting every mode code with every combination of the two lock bits, and by changing the status inputs on every cycle of back-to-back request bursts. A reference function computes the whole result word for each request, and the bench compares that word, for an instance with and an instance without hypervisor support, one clock after the request.

// File: rtl/trapret_pkg.sv
package trapret_pkg;
  typedef enum logic [2:0] {
    MODE_U  = 3'd0,
    MODE_S  = 3'd1,
    MODE_M  = 3'd3,
    MODE_GU = 3'd4,
    MODE_GS = 3'd5
  } priv_e;

  localparam int MODE_W  = 3;
  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT    = 5'd22;
endpackage

// File: rtl/trapret_perm.sv
module trapret_perm
  import trapret_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input  logic [MODE_W-1:0]  mode_i,
  input  logic               lock_m_i,
  input  logic               lock_h_i,
  output logic               allow_o,
  output logic               guest_o,
  output logic [CAUSE_W-1:0] cause_o
);
  // Permission matrix: mode x lock bits -> allow / cause
  always_comb begin
    allow_o = 1'b0;
    guest_o = 1'b0;
    cause_o = CAUSE_ILLEGAL;
    case (mode_i)
      MODE_M:  allow_o = 1'b1;
      MODE_S:  allow_o = ~lock_m_i;
      MODE_GU: if (HYP_EN) cause_o = CAUSE_VIRT;
      MODE_GS: if (HYP_EN) begin
        guest_o = 1'b1;
        allow_o = ~lock_h_i;
        cause_o = CAUSE_VIRT;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trapret_target.sv
module trapret_target
  import trapret_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter bit HYP_EN = 1'b1
) (
  input  logic              guest_i,
  input  logic              pp_i,
  input  logic              pv_i,
  input  logic              g_pp_i,
  input  logic [XLEN-1:0]   epc_i,
  input  logic [XLEN-1:0]   g_epc_i,
  output logic [MODE_W-1:0] next_mode_o,
  output logic [XLEN-1:0]   pc_o
);
  logic [MODE_W-1:0] native_mode;
  logic [MODE_W-1:0] guest_mode;

  generate
    if (HYP_EN) begin : g_hyp
      always_comb begin
        case ({pp_i, pv_i})
          2'b00:   native_mode = MODE_U;
          2'b01:   native_mode = MODE_GU;
          2'b10:   native_mode = MODE_S;
          default: native_mode = MODE_GS;
        endcase
      end
    end else begin : g_nohyp
      logic pv_unused;
      assign pv_unused   = pv_i;
      assign native_mode = pp_i ? MODE_S : MODE_U;
    end
  endgenerate

  assign guest_mode  = g_pp_i ? MODE_GS : MODE_GU;
  assign next_mode_o = guest_i ? guest_mode : native_mode;
  assign pc_o        = guest_i ? g_epc_i : epc_i;
endmodule

// File: rtl/trapret_pipe_reg.sv
module trapret_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/trapret_unit.sv
module trapret_unit
  import trapret_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter bit HYP_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_i,
  input  logic [2:0]         mode_i,
  input  logic               lock_m_i,
  input  logic               lock_h_i,
  input  logic               pp_i,
  input  logic               pie_i,
  input  logic               pv_i,
  input  logic               g_pp_i,
  input  logic               g_pie_i,
  input  logic [XLEN-1:0]    epc_i,
  input  logic [XLEN-1:0]    g_epc_i,
  output logic               done_o,
  output logic               fault_o,
  output logic [4:0]         cause_o,
  output logic [2:0]         next_mode_o,
  output logic [XLEN-1:0]    pc_o,
  output logic               st_wr_o,
  output logic               ie_o,
  output logic               pie_o,
  output logic               pp_o,
  output logic               pv_wr_o,
  output logic               pv_o,
  output logic               g_wr_o,
  output logic               g_ie_o,
  output logic               g_pie_o,
  output logic               g_pp_o
);
  localparam int FLAG_W = 10;
  localparam int RES_W  = 2 + CAUSE_W + MODE_W + XLEN + FLAG_W;

  logic               allow, guest;
  logic [CAUSE_W-1:0] perm_cause;
  logic [MODE_W-1:0]  tgt_mode;
  logic [XLEN-1:0]    tgt_pc;

  trapret_perm #(.HYP_EN(HYP_EN)) u_perm (
    .mode_i   (mode_i),
    .lock_m_i (lock_m_i),
    .lock_h_i (lock_h_i),
    .allow_o  (allow),
    .guest_o  (guest),
    .cause_o  (perm_cause)
  );

  trapret_target #(.XLEN(XLEN), .HYP_EN(HYP_EN)) u_tgt (
    .guest_i     (guest),
    .pp_i        (pp_i),
    .pv_i        (pv_i),
    .g_pp_i      (g_pp_i),
    .epc_i       (epc_i),
    .g_epc_i     (g_epc_i),
    .next_mode_o (tgt_mode),
    .pc_o        (tgt_pc)
  );

  // Result word: strobes, cause, mode, pc, status fields
  logic               d_done, d_fault, d_native;
  logic [CAUSE_W-1:0] d_cause;
  logic [MODE_W-1:0]  d_mode;
  logic [XLEN-1:0]    d_pc;
  logic [FLAG_W-1:0]  d_flags;
  logic [RES_W-1:0]   d_res, q_res;

  always_comb begin
    d_done   = req_i & allow;
    d_fault  = req_i & ~allow;
    d_native = d_done & ~guest;
    d_cause  = d_fault ? perm_cause : '0;
    d_mode   = d_done ? tgt_mode : '0;
    d_pc     = d_done ? tgt_pc : '0;
    // {st_wr, ie, pie, pp, pv_wr, pv, g_wr, g_ie, g_pie, g_pp}
    d_flags  = {d_native, d_native & pie_i, d_native, 1'b0,
                d_native & HYP_EN, 1'b0,
                d_done & guest, d_done & guest & g_pie_i, d_done & guest, 1'b0};
    d_res    = {d_done, d_fault, d_cause, d_mode, d_pc, d_flags};
  end

  trapret_pipe_reg #(.W(RES_W)) u_oreg (
    .clk (clk),
    .rst (rst),
    .d_i (d_res),
    .q_o (q_res)
  );

  assign {done_o, fault_o, cause_o, next_mode_o, pc_o,
          st_wr_o, ie_o, pie_o, pp_o, pv_wr_o, pv_o,
          g_wr_o, g_ie_o, g_pie_o, g_pp_o} = q_res;
endmodule

// File: rtl/trapret_unit_chk.sv
module trapret_unit_chk #(
  parameter bit HYP_EN = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       req_i,
  input logic [2:0] mode_i,
  input logic       lock_m_i,
  input logic       lock_h_i,
  input logic       pp_i,
  input logic       pv_i,
  input logic       done_o,
  input logic       fault_o,
  input logic [4:0] cause_o,
  input logic [2:0] next_mode_o,
  input logic       st_wr_o,
  input logic       pie_o,
  input logic       pp_o,
  input logic       pv_wr_o,
  input logic       pv_o,
  input logic       g_wr_o,
  input logic       g_pie_o,
  input logic       g_pp_o
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!done_o && !fault_o));

  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fault_o));

  a_r2_answer: assert property (@(posedge clk) disable iff (rst)
    req_i |=> (done_o || fault_o));

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!done_o && !fault_o));

  a_r3_machine_done: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == 3'd3) |=> done_o);

  a_r3_user_fault: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == 3'd0) |=> (fault_o && cause_o == 5'd2));

  a_r4_s_locked: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == 3'd1 && lock_m_i) |=> (fault_o && cause_o == 5'd2));

  a_r5_gs_locked: assert property (@(posedge clk) disable iff (rst)
    (HYP_EN && req_i && mode_i == 3'd5 && lock_h_i) |=> (fault_o && cause_o == 5'd22));

  a_r6_native_mode: assert property (@(posedge clk) disable iff (rst)
    (HYP_EN && st_wr_o) |-> (next_mode_o ==
      ($past(pp_i) ? ($past(pv_i) ? 3'd5 : 3'd1) : ($past(pv_i) ? 3'd4 : 3'd0))));

  a_r7_native_fields: assert property (@(posedge clk) disable iff (rst)
    st_wr_o |-> (done_o && pie_o && !pp_o && !pv_o && !g_wr_o));

  a_r8_guest_fields: assert property (@(posedge clk) disable iff (rst)
    g_wr_o |-> (done_o && g_pie_o && !g_pp_o && !st_wr_o && !pv_wr_o &&
                (next_mode_o == 3'd4 || next_mode_o == 3'd5)));

  a_r9_fault_no_write: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!st_wr_o && !pv_wr_o && !g_wr_o &&
                 (cause_o == 5'd2 || cause_o == 5'd22)));

  a_r10_bad_code: assert property (@(posedge clk) disable iff (rst)
    (req_i && (mode_i == 3'd2 || mode_i == 3'd6 || mode_i == 3'd7))
      |=> (fault_o && cause_o == 5'd2));

  a_r11_no_pv_write: assert property (@(posedge clk) disable iff (rst)
    !HYP_EN |-> !pv_wr_o);
endmodule

bind trapret_unit trapret_unit_chk #(.HYP_EN(HYP_EN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .mode_i      (mode_i),
  .lock_m_i    (lock_m_i),
  .lock_h_i    (lock_h_i),
  .pp_i        (pp_i),
  .pv_i        (pv_i),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .cause_o     (cause_o),
  .next_mode_o (next_mode_o),
  .st_wr_o     (st_wr_o),
  .pie_o       (pie_o),
  .pp_o        (pp_o),
  .pv_wr_o     (pv_wr_o),
  .pv_o        (pv_o),
  .g_wr_o      (g_wr_o),
  .g_pie_o     (g_pie_o),
  .g_pp_o      (g_pp_o)
);

// File: tb/tb_trapret_unit.sv
module tb_trapret_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  typedef struct packed {
    logic            req;
    logic [2:0]      mode;
    logic            lock_m, lock_h, pp, pie, pv, g_pp, g_pie;
    logic [XLEN-1:0] epc, g_epc;
  } stim_t;

  typedef struct packed {
    logic            done, fault;
    logic [4:0]      cause;
    logic [2:0]      mode;
    logic [XLEN-1:0] pc;
    logic            st_wr, ie, pie, pp, pv_wr, pv, g_wr, g_ie, g_pie, g_pp;
  } res_t;

  logic  clk = 1'b0;
  logic  rst = 1'b1;
  stim_t s   = '0;
  res_t  obs_h, obs_n;
  int    n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trapret_unit #(.XLEN(XLEN), .HYP_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .req_i(s.req), .mode_i(s.mode),
    .lock_m_i(s.lock_m), .lock_h_i(s.lock_h), .pp_i(s.pp), .pie_i(s.pie),
    .pv_i(s.pv), .g_pp_i(s.g_pp), .g_pie_i(s.g_pie),
    .epc_i(s.epc), .g_epc_i(s.g_epc),
    .done_o(obs_h.done), .fault_o(obs_h.fault), .cause_o(obs_h.cause),
    .next_mode_o(obs_h.mode), .pc_o(obs_h.pc),
    .st_wr_o(obs_h.st_wr), .ie_o(obs_h.ie), .pie_o(obs_h.pie), .pp_o(obs_h.pp),
    .pv_wr_o(obs_h.pv_wr), .pv_o(obs_h.pv),
    .g_wr_o(obs_h.g_wr), .g_ie_o(obs_h.g_ie), .g_pie_o(obs_h.g_pie),
    .g_pp_o(obs_h.g_pp));

  trapret_unit #(.XLEN(XLEN), .HYP_EN(1'b0)) dut_nh (
    .clk(clk), .rst(rst), .req_i(s.req), .mode_i(s.mode),
    .lock_m_i(s.lock_m), .lock_h_i(s.lock_h), .pp_i(s.pp), .pie_i(s.pie),
    .pv_i(s.pv), .g_pp_i(s.g_pp), .g_pie_i(s.g_pie),
    .epc_i(s.epc), .g_epc_i(s.g_epc),
    .done_o(obs_n.done), .fault_o(obs_n.fault), .cause_o(obs_n.cause),
    .next_mode_o(obs_n.mode), .pc_o(obs_n.pc),
    .st_wr_o(obs_n.st_wr), .ie_o(obs_n.ie), .pie_o(obs_n.pie), .pp_o(obs_n.pp),
    .pv_wr_o(obs_n.pv_wr), .pv_o(obs_n.pv),
    .g_wr_o(obs_n.g_wr), .g_ie_o(obs_n.g_ie), .g_pie_o(obs_n.g_pie),
    .g_pp_o(obs_n.g_pp));

  // Reference result from the requirements
  function automatic res_t model(bit hyp, stim_t t);
    res_t r = '0;
    bit ok = 1'b0, gst = 1'b0;
    logic [4:0] c = 5'd2;
    if (!t.req) return r;
    if (t.mode == 3'd3) ok = 1'b1;
    else if (t.mode == 3'd1) ok = !t.lock_m;
    else if (hyp && t.mode == 3'd5) begin gst = 1'b1; ok = !t.lock_h; c = 5'd22; end
    else if (hyp && t.mode == 3'd4) c = 5'd22;
    if (!ok) begin
      r.fault = 1'b1; r.cause = c;
    end else if (gst) begin
      r.done = 1'b1; r.mode = t.g_pp ? 3'd5 : 3'd4; r.pc = t.g_epc;
      r.g_wr = 1'b1; r.g_ie = t.g_pie; r.g_pie = 1'b1; r.g_pp = 1'b0;
    end else begin
      r.done = 1'b1; r.pc = t.epc;
      if (hyp) r.mode = t.pp ? (t.pv ? 3'd5 : 3'd1) : (t.pv ? 3'd4 : 3'd0);
      else     r.mode = t.pp ? 3'd1 : 3'd0;
      r.st_wr = 1'b1; r.ie = t.pie; r.pie = 1'b1; r.pp = 1'b0;
      r.pv_wr = hyp; r.pv = 1'b0;
    end
    return r;
  endfunction

  function automatic string tag_of(bit hyp, stim_t t);
    if (!t.req) return "R2";
    if (!hyp && (t.mode == 3'd4 || t.mode == 3'd5 || t.pv)) return "R11";
    case (t.mode)
      3'd3: return "R3 R6 R7";
      3'd1: return t.lock_m ? "R4 R9" : "R4 R6 R7";
      3'd0: return "R3 R9";
      3'd4: return "R3 R9";
      3'd5: return t.lock_h ? "R5 R9" : "R5 R8";
      default: return "R10 R9";
    endcase
  endfunction

  task automatic check(string tag, string which, res_t got, res_t exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] got=%h exp=%h", tag, which, got, exp);
    end
  endtask

  // Drive a request at a negedge, compare at the next negedge
  task automatic step(stim_t t);
    s = t;
    @(negedge clk);
    check(tag_of(1'b1, t), "hyp", obs_h, model(1'b1, t));
    check(tag_of(1'b0, t), "nohyp", obs_n, model(1'b0, t));
  endtask

  function automatic stim_t rnd_stim(bit req);
    stim_t t;
    t.req = req;
    t.mode = 3'($urandom_range(0, 7));
    t.lock_m = 1'($urandom); t.lock_h = 1'($urandom);
    t.pp = 1'($urandom); t.pie = 1'($urandom); t.pv = 1'($urandom);
    t.g_pp = 1'($urandom); t.g_pie = 1'($urandom);
    t.epc = {$urandom, $urandom}; t.g_epc = {$urandom, $urandom};
    return t;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    stim_t t;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "hyp", obs_h, '0);
    check("R1", "nohyp", obs_n, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "hyp", obs_h, '0);
    check("R1", "nohyp", obs_n, '0);

    // R3 R4 R5 R10 R11: every mode code against every lock pair
    for (int m = 0; m < 8; m++)
      for (int l = 0; l < 4; l++) begin
        t = rnd_stim(1'b1);
        t.mode = 3'(m); t.lock_m = l[1]; t.lock_h = l[0];
        step(t);
      end

    // R6 R7: native mode mapping from machine mode, all {pp,pv}
    for (int k = 0; k < 4; k++) begin
      t = rnd_stim(1'b1);
      t.mode = 3'd3; t.pp = k[1]; t.pv = k[0];
      step(t);
    end

    // R8: guest return, both saved guest privileges, lock_m set (no effect)
    for (int k = 0; k < 4; k++) begin
      t = rnd_stim(1'b1);
      t.mode = 3'd5; t.lock_h = 1'b0; t.lock_m = 1'b1;
      t.g_pp = k[0]; t.g_pie = k[1];
      step(t);
    end

    // R2: idle cycles between and after requests
    step(rnd_stim(1'b0));
    step(rnd_stim(1'b0));

    // R2 R9: back-to-back fault then completion
    t = rnd_stim(1'b1); t.mode = 3'd0; step(t);
    t = rnd_stim(1'b1); t.mode = 3'd3; step(t);
    t = rnd_stim(1'b1); t.mode = 3'd4; step(t);
    t = rnd_stim(1'b1); t.mode = 3'd5; t.lock_h = 1'b0; step(t);

    // Random mix with bursts and gaps
    for (int i = 0; i < 3000; i++)
      step(rnd_stim($urandom_range(0, 3) != 0));

    step(rnd_stim(1'b0));
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule